// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block sits next to the exception controller of a pipelined processor. It gathers eight interrupt lines into one qualified request. Two of the lines are software bits that the controller writes. Five come from external pins. The top line merges a sixth external pin with the match of a free-running counter against a compare value. External pins pass through a two-flop synchroniser. The block keeps the resulting pending vector, applies the per-line mask and the global enable, and blocks all requests while the core is at exception level or error level. A request is only raised at an instruction boundary, which is the only point where the asynchronous interrupt may be taken.

A separate non-maskable input is synchronised and edge-detected, so every assertion of that input gives exactly one single-cycle request, however long the input stays high. No status, mask or level bit blocks it. The block does not choose between pending lines and does not form vector addresses; the exception controller reads the pending vector and does that work.

Top module: `irq_qualifier`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `ip_o`, `irq_req_o` and `nmi_req_o` are all zero.
- R2: A write on `sw_wr_i` loads `sw_wdata_i` into `ip_o[1:0]` at that clock edge, and the bits hold until the next write.
- R3: External pin `ext_irq_i[k]` shows up on `ip_o[k+2]` exactly two clock edges after it changes: `ext_irq_i[4:0]` drive `ip_o[6:2]`, and `ext_irq_i[5]` is ORed into `ip_o[7]`.
- R4: `irq_req_o` is 1 exactly when `boundary_i`, `ie_i` and at least one bit of `ip_o & im_i` are 1, and both `exl_i` and `erl_i` are 0.
- R5: While `exl_i` or `erl_i` is 1, `irq_req_o` stays 0 whatever `ie_i`, `im_i` and the pending bits are.
- R6: A counter starts at zero when reset is released and adds one on every clock edge. On the edge where the counter equals the compare value, the timer pending bit is set. It drives `ip_o[7]` and stays set.
- R7: A write on `cmp_wr_i` loads `cmp_wdata_i` as the new compare value and clears the timer pending bit at that edge. The write wins over a match in the same cycle.
- R8: Each rising edge of `nmi_i` gives exactly one `nmi_req_o` pulse, one cycle wide, two clock edges after the rise, however long `nmi_i` stays high.
- R9: `nmi_req_o` does not depend on `ie_i`, `im_i`, `exl_i`, `erl_i` or `boundary_i`.
- R10: `ip_o` shows pending bits whatever the mask and enable are. Masking only affects `irq_req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 6 | External interrupt pins, asynchronous |
| sw_wr_i | input | 1 | Write strobe for the software pending bits |
| sw_wdata_i | input | 2 | New value of the software pending bits |
| cmp_wr_i | input | 1 | Write strobe for the compare value |
| cmp_wdata_i | input | 32 | New compare value |
| im_i | input | 8 | Per-line interrupt mask |
| ie_i | input | 1 | Global interrupt enable |
| exl_i | input | 1 | Core is at exception level |
| erl_i | input | 1 | Core is at error level |
| boundary_i | input | 1 | Current cycle is an instruction boundary |
| nmi_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| ip_o | output | 8 | Pending vector for the cause register |
| irq_req_o | output | 1 | Qualified maskable interrupt request |
| nmi_req_o | output | 1 | Single-cycle non-maskable request |

## Verification
Some properties are checked on every cycle:
- a request only appears with the enable set at a boundary;
- exception or error level always blocks the request;
- the two-edge synchroniser latency;
- the software write path;
- the set, hold and clear rules of the timer pending bit;
- the single-cycle width of the non-maskable pulse.

Other behaviour needs the bench's scenarios:
- the full qualification truth table over mask, enable and level combinations;
- the exact cycle on which a counter match lands against the bench's own cycle count;
- a non-maskable input held high for many cycles giving exactly one pulse while every mask is closed.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Qualification of the maskable request: level bits override the enable.
  function automatic logic irq_qualify(input logic [7:0] pend,
                                       input logic [7:0] mask,
                                       input logic       gie,
                                       input logic       exc_lvl,
                                       input logic       err_lvl,
                                       input logic       bnd);
    logic any_line;
    any_line = |(pend & mask);
    return bnd & gie & ~exc_lvl & ~err_lvl & any_line;
  endfunction

  // One-shot rising edge from the current and the previous sample.
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_i[g];
          stab_q <= meta_q;
        end
      end
      assign sync_o[g] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             match_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             pend_q;

  assign match_o = (cnt_q == cmp_q);
  assign pend_o  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cmp_wr_i) begin
        cmp_q  <= cmp_wdata_i;
        pend_q <= 1'b0;
      end else if (match_o) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  output logic pulse_o
);
  logic nmi_s, nmi_prev_q;

  irq_sync #(.W(1)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(nmi_i),
    .sync_o (nmi_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_prev_q <= 1'b0;
    else        nmi_prev_q <= nmi_s;
  end

  assign pulse_o = rise_of(nmi_s, nmi_prev_q);
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
  import irq_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_SW  = 2,
  parameter int CNT_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EXT-1:0]         ext_irq_i,
  input  logic                       sw_wr_i,
  input  logic [NUM_SW-1:0]          sw_wdata_i,
  input  logic                       cmp_wr_i,
  input  logic [CNT_W-1:0]           cmp_wdata_i,
  input  logic [NUM_EXT+NUM_SW-1:0]  im_i,
  input  logic                       ie_i,
  input  logic                       exl_i,
  input  logic                       erl_i,
  input  logic                       boundary_i,
  input  logic                       nmi_i,
  output logic [NUM_EXT+NUM_SW-1:0]  ip_o,
  output logic                       irq_req_o,
  output logic                       nmi_req_o
);
  localparam int NUM_LINES = NUM_EXT + NUM_SW;

  logic [NUM_SW-1:0]  sw_q;
  logic [NUM_EXT-1:0] ext_s;
  logic               tim_match;
  logic               tim_pend;
  logic [NUM_LINES-1:0] pend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_q <= '0;
    else if (sw_wr_i) sw_q <= sw_wdata_i;
  end

  irq_sync #(.W(NUM_EXT)) i_ext_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_irq_i),
    .sync_o (ext_s)
  );

  irq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_wdata_i(cmp_wdata_i),
    .match_o    (tim_match),
    .pend_o     (tim_pend)
  );

  irq_nmi_edge i_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_i  (nmi_i),
    .pulse_o(nmi_req_o)
  );

  assign pend_vec = {ext_s[NUM_EXT-1] | tim_pend, ext_s[NUM_EXT-2:0], sw_q};
  assign ip_o     = pend_vec;

  generate
    if (NUM_LINES == 8) begin : g_std
      assign irq_req_o = irq_qualify(pend_vec, im_i, ie_i, exl_i, erl_i, boundary_i);
    end else begin : g_wide
      assign irq_req_o = boundary_i & ie_i & ~exl_i & ~erl_i & (|(pend_vec & im_i));
    end
  endgenerate

  logic unused_match;
  assign unused_match = tim_match;
endmodule

// File: rtl/irq_qualifier_chk.sv
module irq_qualifier_chk #(
  parameter int NUM_EXT = 6,
  parameter int NUM_SW  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_EXT-1:0]        ext_irq_i,
  input logic                      sw_wr_i,
  input logic [NUM_SW-1:0]         sw_wdata_i,
  input logic                      cmp_wr_i,
  input logic                      nmi_i,
  input logic                      ie_i,
  input logic                      exl_i,
  input logic                      erl_i,
  input logic                      boundary_i,
  input logic [NUM_EXT+NUM_SW-1:0] ip_o,
  input logic                      irq_req_o,
  input logic                      nmi_req_o,
  input logic                      tim_pend
);
  localparam int NUM_LINES = NUM_EXT + NUM_SW;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_sw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> ip_o[NUM_SW-1:0] == $past(sw_wdata_i));

  p_ext_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> ip_o[NUM_LINES-2:NUM_SW] == $past(ext_irq_i[NUM_EXT-2:0], 2));

  p_ext_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(ext_irq_i[NUM_EXT-1], 2)) |-> ip_o[NUM_LINES-1]);

  p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (ie_i && boundary_i && (ip_o != '0)));

  p_level_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_i || erl_i) |-> !irq_req_o);

  p_timer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_pend && !cmp_wr_i) |=> tim_pend);

  p_timer_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tim_pend |-> ip_o[NUM_LINES-1]);

  p_timer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |=> !tim_pend);

  p_nmi_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |=> !nmi_req_o);

  p_nmi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && nmi_req_o) |-> $past(nmi_i, 2));
endmodule

bind irq_qualifier irq_qualifier_chk #(.NUM_EXT(NUM_EXT), .NUM_SW(NUM_SW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_irq_i (ext_irq_i),
  .sw_wr_i   (sw_wr_i),
  .sw_wdata_i(sw_wdata_i),
  .cmp_wr_i  (cmp_wr_i),
  .nmi_i     (nmi_i),
  .ie_i      (ie_i),
  .exl_i     (exl_i),
  .erl_i     (erl_i),
  .boundary_i(boundary_i),
  .ip_o      (ip_o),
  .irq_req_o (irq_req_o),
  .nmi_req_o (nmi_req_o),
  .tim_pend  (tim_pend)
);

// File: tb/test_irq_qualifier.sv
`timescale 1ns/1ps
module test_irq_qualifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_irq_i = '0;
  logic        sw_wr_i = 1'b0;
  logic [1:0]  sw_wdata_i = '0;
  logic        cmp_wr_i = 1'b0;
  logic [31:0] cmp_wdata_i = '0;
  logic [7:0]  im_i = '0;
  logic        ie_i = 1'b0, exl_i = 1'b0, erl_i = 1'b0, boundary_i = 1'b0;
  logic        nmi_i = 1'b0;
  logic [7:0]  ip_o;
  logic        irq_req_o, nmi_req_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          ended = 1'b0;
  int unsigned bcyc;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;

  irq_qualifier i_irq_qualifier (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
    .im_i(im_i), .ie_i(ie_i), .exl_i(exl_i), .erl_i(erl_i),
    .boundary_i(boundary_i), .nmi_i(nmi_i), .ip_o(ip_o),
    .irq_req_o(irq_req_o), .nmi_req_o(nmi_req_o)
  );

  // Fields: [14] ie [13] exl [12] erl [11] boundary [10:3] mask [2:1] sw bits [0] expected request
  localparam logic [14:0] VECS [9] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 2'b01, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 2'b01, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 2'b11, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 2'b11, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 2'b11, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b11, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 2'b10, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 2'b10, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 2'b11, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, bcyc);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic nmi_round(output int pulses, output int first_at);
    pulses = 0; first_at = -1;
    nmi_i = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (nmi_req_o) begin
        pulses++;
        if (first_at < 0) first_at = k;
      end
    end
    nmi_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pulses, first_at;
    int unsigned c_tgt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ip during reset", 32'(ip_o), 0);
    rst_n = 1'b1;
    ie_i = 1'b1; boundary_i = 1'b1; im_i = 8'hFF;
    @(negedge clk);
    chk("R1 ip after reset", 32'(ip_o), 0);
    chk("R1 req after reset", 32'(irq_req_o), 0);
    chk("R1 nmi after reset", 32'(nmi_req_o), 0);

    // R2 R4 R5 R10: qualification table
    foreach (VECS[i]) begin
      logic [14:0] v;
      v = VECS[i];
      ie_i = v[14]; exl_i = v[13]; erl_i = v[12]; boundary_i = v[11];
      im_i = v[10:3]; sw_wr_i = 1'b1; sw_wdata_i = v[2:1];
      @(negedge clk);
      sw_wr_i = 1'b0;
      chk("R2 R10 sw bits shown", 32'(ip_o[1:0]), 32'(v[2:1]));
      chk("R4 R5 request", 32'(irq_req_o), 32'(v[0]));
      @(negedge clk);
      chk("R2 sw bits hold", 32'(ip_o[1:0]), 32'(v[2:1]));
    end

    // R3: external lines, two-edge latency
    sw_wr_i = 1'b1; sw_wdata_i = 2'b00;
    ie_i = 1'b1; exl_i = 1'b0; erl_i = 1'b0; boundary_i = 1'b1; im_i = 8'hFF;
    @(negedge clk);
    sw_wr_i = 1'b0;
    ext_irq_i = 6'b011010;
    @(negedge clk);
    chk("R3 one edge not yet", 32'(ip_o), 0);
    chk("R4 no request yet", 32'(irq_req_o), 0);
    @(negedge clk);
    chk("R3 two edges", 32'(ip_o), 32'({6'b011010, 2'b00}));
    chk("R4 external request", 32'(irq_req_o), 1);
    im_i = 8'h01;
    #1;
    chk("R10 masked still pending", 32'(ip_o), 32'({6'b011010, 2'b00}));
    chk("R4 masked no request", 32'(irq_req_o), 0);
    im_i = 8'hFF;
    ext_irq_i = 6'b100000;
    repeat (2) @(negedge clk);
    chk("R3 top pin to line 7", 32'(ip_o), 32'h80);
    ext_irq_i = '0;
    repeat (2) @(negedge clk);
    chk("R3 lines cleared", 32'(ip_o), 0);

    // R6: counter match sets line 7 on the exact edge
    c_tgt = bcyc + 8;
    cmp_wr_i = 1'b1; cmp_wdata_i = 32'(c_tgt);
    @(negedge clk);
    cmp_wr_i = 1'b0;
    while (bcyc < c_tgt) begin
      chk("R6 no match yet", 32'(ip_o[7]), 0);
      @(negedge clk);
    end
    chk("R6 count equals compare, not latched", 32'(ip_o[7]), 0);
    @(negedge clk);
    chk("R6 match sets line 7", 32'(ip_o[7]), 1);
    chk("R6 timer raises request", 32'(irq_req_o), 1);
    repeat (5) @(negedge clk);
    chk("R6 pending holds", 32'(ip_o[7]), 1);

    // R7: compare write clears
    cmp_wr_i = 1'b1; cmp_wdata_i = 32'(bcyc + 1000);
    @(negedge clk);
    cmp_wr_i = 1'b0;
    chk("R7 write clears timer line", 32'(ip_o[7]), 0);
    repeat (3) @(negedge clk);
    chk("R7 stays clear", 32'(ip_o[7]), 0);

    // R7: write in the same cycle as a match wins
    c_tgt = bcyc + 5;
    cmp_wr_i = 1'b1; cmp_wdata_i = 32'(c_tgt);
    @(negedge clk);
    cmp_wr_i = 1'b0;
    while (bcyc < c_tgt) @(negedge clk);
    cmp_wr_i = 1'b1; cmp_wdata_i = 32'(bcyc + 1000);
    @(negedge clk);
    cmp_wr_i = 1'b0;
    chk("R7 write beats match", 32'(ip_o[7]), 0);

    // R8 R9: NMI with every mask closed
    ie_i = 1'b0; exl_i = 1'b1; erl_i = 1'b1; boundary_i = 1'b0; im_i = 8'h00;
    nmi_round(pulses, first_at);
    chk("R8 R9 one pulse masked", 32'(pulses), 1);
    chk("R8 pulse latency", 32'(first_at), 2);
    ie_i = 1'b1; exl_i = 1'b0; erl_i = 1'b0; boundary_i = 1'b1; im_i = 8'hFF;
    nmi_round(pulses, first_at);
    chk("R8 R9 one pulse unmasked", 32'(pulses), 1);
    chk("R8 second latency", 32'(first_at), 2);

    finish_run();
  end
endmodule